// File: doc/BRIEF.md
# Sixteen-Pin Shared GPIO Port with Change Listeners

This block is a 16-pin general-purpose I/O port. Software programs it through two registers on a simple valid/write/address/data bus. A 32-bit configuration word holds, for every pin, an output-enable bit and a pull-up bit, interleaved pin by pin. A 16-bit drive register holds the value the processor places on its output pins. An on-chip peripheral can also drive any pin through its own direction and data inputs.

Each pin level is the wired-OR of three sources: the processor drive on pins it enables, the peripheral drive on pins the peripheral enables, and the pull-up on pins that neither side enables. A read of the drive register returns these resolved levels rather than the stored value, so software sees the actual pin state.

Every register write that changes the resolved levels produces a change mask. Up to four listeners, each with an enable and a 16-bit trigger mask, receive a one-cycle notify pulse when their mask overlaps the changed pins. A listener can use the pulse to update the peripheral drive.

Top module: `gpio_port`

## Requirements
- R1: After synchronous reset, the configuration and drive registers are zero, so with the peripheral idle every pin line reads 0, bus_rvalid is 0 and no notify is raised.
- R2: Configuration bit 2n is the processor output-enable of pin n, and bit 2n+1 is its pull-up enable, for n = 0..15.
- R3: Pin n resolves to (oe_n AND drive_n) OR (periph_dir_n AND periph_data_n) OR (NOT(oe_n OR periph_dir_n) AND pullup_n). A processor drive of 0 and a peripheral drive of 1 on one pin give 1.
- R4: A read at address 1 returns the resolved pin levels in bits 15:0 and zero above, not the stored drive value.
- R5: A write that leaves the resolved levels unchanged raises no notify and reports a zero change mask.
- R6: In the cycle after a write that changes the levels, change_mask equals the old levels XOR the new levels.
- R7: Listener i pulses lsn_notify[i] only if lsn_en[i] is 1 and its trigger mask lsn_mask[16i+15:16i] ANDed with the change mask is nonzero.
- R8: Notify pulses last exactly one cycle. They appear only in the cycle right after a committed write and never follow a peripheral input change alone.
- R9: A read issued in one cycle returns bus_rvalid and bus_rdata in the next cycle. Address 0 returns the full 32-bit configuration word.
- R10: Addresses 2 and 3 are unmapped. Writes to them change no state and raise no notify, and reads from them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus access this cycle |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 2 | 0 configuration, 1 drive/levels, 2-3 unmapped |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| bus_rvalid | output | 1 | Read data valid |
| periph_dir | input | 16 | Peripheral output-enable per pin |
| periph_data | input | 16 | Peripheral drive value per pin |
| pin_lines | output | 16 | Resolved pin levels |
| lsn_en | input | 4 | Listener registered flags |
| lsn_mask | input | 64 | Trigger masks, 16 bits per listener |
| lsn_notify | output | 4 | One-cycle notify pulse per listener |
| change_mask | output | 16 | Changed pins during a notify cycle |

## Verification
The resolution is tried with pins driven only by the processor, pins held only by pull-ups, pins driven by the peripheral, and one pin where the processor drives 0 against a peripheral 1. These cases separate the three terms of the OR and the masking of the pull-up term. Writes are chosen so that some change levels and some do not, and so that the change hits one listener's mask, several masks, or only a disabled listener. These cases separate the unchanged-levels rule from the per-listener gating. Two writes issued back to back check that the old levels are captured per write and not once per burst.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int unsigned PINS      = 16;
    localparam int unsigned CTRL_BITS = 2 * PINS;
    localparam int unsigned BUS_BITS  = 32;
    localparam int unsigned ADDR_BITS = 2;

    typedef logic [PINS-1:0]      pin_vec_t;
    typedef logic [CTRL_BITS-1:0] ctrl_word_t;

    typedef enum logic [ADDR_BITS-1:0] {
        SEL_CFG   = 2'd0,
        SEL_DRIVE = 2'd1,
        SEL_RSV2  = 2'd2,
        SEL_RSV3  = 2'd3
    } reg_sel_t;

    typedef struct packed {
        pin_vec_t oe;
        pin_vec_t pu;
    } pin_cfg_t;

    // Even bit of each pair is output-enable, odd bit is pull-up
    function automatic pin_cfg_t split_cfg(input ctrl_word_t w);
        pin_cfg_t r;
        for (int n = 0; n < int'(PINS); n++) begin
            r.oe[n] = w[2*n];
            r.pu[n] = w[2*n+1];
        end
        return r;
    endfunction

    function automatic pin_vec_t resolve_pins(input pin_cfg_t c, input pin_vec_t drv,
                                              input pin_vec_t pdir, input pin_vec_t pdat);
        return (c.oe & drv) | (pdir & pdat) | (~(c.oe | pdir) & c.pu);
    endfunction

endpackage

// File: rtl/gpio_port_resolve.sv
module gpio_port_resolve
    import gpio_port_pkg::*;
(
    input  logic [CTRL_BITS-1:0] cfg_word,
    input  logic [PINS-1:0]      drive_val,
    input  logic [PINS-1:0]      periph_dir,
    input  logic [PINS-1:0]      periph_data,
    output logic [PINS-1:0]      lines
);
    pin_cfg_t cfg;

    always_comb begin
        cfg   = split_cfg(cfg_word);
        lines = resolve_pins(cfg, drive_val, periph_dir, periph_data);
    end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic [ADDR_BITS-1:0] bus_addr,
    input  logic [BUS_BITS-1:0]  bus_wdata,
    input  logic [PINS-1:0]      lines,
    output logic [CTRL_BITS-1:0] cfg_q,
    output logic [PINS-1:0]      drive_q,
    output logic [BUS_BITS-1:0]  rdata_q,
    output logic                 rvalid_q,
    output logic                 commit
);
    reg_sel_t sel;
    logic     wr_en;
    logic     rd_en;

    always_comb begin
        sel    = reg_sel_t'(bus_addr);
        wr_en  = bus_valid && bus_write;
        rd_en  = bus_valid && !bus_write;
        commit = wr_en && (sel == SEL_CFG || sel == SEL_DRIVE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= '0;
            drive_q  <= '0;
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= rd_en;
            if (wr_en) begin
                case (sel)
                    SEL_CFG:   cfg_q   <= bus_wdata[CTRL_BITS-1:0];
                    SEL_DRIVE: drive_q <= bus_wdata[PINS-1:0];
                    default:   ;
                endcase
            end
            if (rd_en) begin
                case (sel)
                    SEL_CFG:   rdata_q <= BUS_BITS'(cfg_q);
                    SEL_DRIVE: rdata_q <= BUS_BITS'(lines);
                    default:   rdata_q <= '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/gpio_port_notify.sv
module gpio_port_notify
    import gpio_port_pkg::*;
#(
    parameter int unsigned NUM_LSN = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    commit,
    input  logic [PINS-1:0]         lines,
    input  logic [NUM_LSN-1:0]      lsn_en,
    input  logic [NUM_LSN*PINS-1:0] lsn_mask,
    output logic [NUM_LSN-1:0]      lsn_notify,
    output logic [PINS-1:0]         change_mask
);
    logic            pend_q;
    logic [PINS-1:0] prev_q;

    // Capture the levels seen before the write takes effect
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            prev_q <= '0;
        end else begin
            pend_q <= commit;
            if (commit) prev_q <= lines;
        end
    end

    always_comb change_mask = pend_q ? (lines ^ prev_q) : '0;

    for (genvar i = 0; i < int'(NUM_LSN); i++) begin : g_lsn
        always_comb lsn_notify[i] = lsn_en[i] && (|(lsn_mask[i*PINS +: PINS] & change_mask));
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int unsigned NUM_LSN = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    bus_valid,
    input  logic                    bus_write,
    input  logic [ADDR_BITS-1:0]    bus_addr,
    input  logic [BUS_BITS-1:0]     bus_wdata,
    output logic [BUS_BITS-1:0]     bus_rdata,
    output logic                    bus_rvalid,
    input  logic [PINS-1:0]         periph_dir,
    input  logic [PINS-1:0]         periph_data,
    output logic [PINS-1:0]         pin_lines,
    input  logic [NUM_LSN-1:0]      lsn_en,
    input  logic [NUM_LSN*PINS-1:0] lsn_mask,
    output logic [NUM_LSN-1:0]      lsn_notify,
    output logic [PINS-1:0]         change_mask
);
    logic [CTRL_BITS-1:0] cfg_q;
    logic [PINS-1:0]      drive_q;
    logic                 commit;

    gpio_port_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .lines     (pin_lines),
        .cfg_q     (cfg_q),
        .drive_q   (drive_q),
        .rdata_q   (bus_rdata),
        .rvalid_q  (bus_rvalid),
        .commit    (commit)
    );

    gpio_port_resolve u_resolve (
        .cfg_word    (cfg_q),
        .drive_val   (drive_q),
        .periph_dir  (periph_dir),
        .periph_data (periph_data),
        .lines       (pin_lines)
    );

    gpio_port_notify #(.NUM_LSN(NUM_LSN)) u_notify (
        .clk         (clk),
        .rst         (rst),
        .commit      (commit),
        .lines       (pin_lines),
        .lsn_en      (lsn_en),
        .lsn_mask    (lsn_mask),
        .lsn_notify  (lsn_notify),
        .change_mask (change_mask)
    );
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
    import gpio_port_pkg::*;
#(
    parameter int unsigned NUM_LSN = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               bus_valid,
    input logic               bus_write,
    input logic               bus_rvalid,
    input logic [NUM_LSN-1:0] lsn_en,
    input logic [NUM_LSN-1:0] lsn_notify,
    input logic [PINS-1:0]    change_mask
);
    // R8: a pulse is always preceded by a write in the previous cycle
    a_r8_notify_after_write: assert property (@(posedge clk) disable iff (rst)
        (|lsn_notify) |-> $past(bus_valid && bus_write));

    // R8: without a new write the pulse drops after one cycle
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
        ((|lsn_notify) && !(bus_valid && bus_write)) |=> (lsn_notify == '0));

    // R7: a disabled listener never pulses
    a_r7_enable_gates: assert property (@(posedge clk) disable iff (rst)
        (lsn_notify & ~lsn_en) == '0);

    // R5: a pulse needs a nonzero change
    a_r5_change_nonzero: assert property (@(posedge clk) disable iff (rst)
        (|lsn_notify) |-> (change_mask != '0));

    // R9: read data comes back exactly one cycle later
    a_r9_read_latency: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_write) |=> bus_rvalid);

    a_r9_no_spurious_rvalid: assert property (@(posedge clk) disable iff (rst)
        !(bus_valid && !bus_write) |=> !bus_rvalid);
endmodule

bind gpio_port gpio_port_chk #(.NUM_LSN(NUM_LSN)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_valid   (bus_valid),
    .bus_write   (bus_write),
    .bus_rvalid  (bus_rvalid),
    .lsn_en      (lsn_en),
    .lsn_notify  (lsn_notify),
    .change_mask (change_mask)
);

// File: tb/tb_gpio_port.sv
module tb_gpio_port;
    localparam int CLK_PERIOD = 10;
    localparam int NL = 4;
    localparam int NP = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_valid = 1'b0;
    logic              bus_write = 1'b0;
    logic [1:0]        bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              bus_rvalid;
    logic [NP-1:0]     periph_dir = '0;
    logic [NP-1:0]     periph_data = '0;
    logic [NP-1:0]     pin_lines;
    logic [NL-1:0]     lsn_en = 4'b1011;
    logic [NL*NP-1:0]  lsn_mask = {16'h8000, 16'hFFFF, 16'h00F0, 16'h000F};
    logic [NL-1:0]     lsn_notify;
    logic [NP-1:0]     change_mask;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    // bench-side model of the registers
    logic [31:0] m_cfg = '0;
    logic [15:0] m_drv = '0;

    gpio_port dut (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .periph_dir(periph_dir), .periph_data(periph_data),
        .pin_lines(pin_lines), .lsn_en(lsn_en), .lsn_mask(lsn_mask),
        .lsn_notify(lsn_notify), .change_mask(change_mask)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] model_lines();
        logic [15:0] r;
        for (int n = 0; n < NP; n++) begin
            logic oe, pu;
            oe = m_cfg[2*n];
            pu = m_cfg[2*n+1];
            r[n] = (oe & m_drv[n]) | (periph_dir[n] & periph_data[n]) |
                   (!oe && !periph_dir[n] && pu);
        end
        return r;
    endfunction

    function automatic logic [3:0] model_notify(logic [15:0] chg);
        logic [3:0] r;
        for (int i = 0; i < NL; i++)
            r[i] = lsn_en[i] && ((lsn_mask[i*NP +: NP] & chg) != 0);
        return r;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: pops expected read data as the design returns it
    always @(negedge clk) begin
        if (!rst && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                check("R9 unexpected rvalid", 32'h1, 32'h0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, bus_rdata, e);
            end
        end
    end

    task automatic do_read(logic [1:0] a, logic [31:0] exp, string tag);
        @(negedge clk);
        bus_valid = 1; bus_write = 0; bus_addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_valid = 0;
    endtask

    task automatic do_write(logic [1:0] a, logic [31:0] d, string tag);
        logic [15:0] old_l, new_l, chg;
        @(negedge clk);
        old_l = model_lines();
        bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
        if (a == 2'd0) m_cfg = d;
        else if (a == 2'd1) m_drv = d[15:0];
        new_l = model_lines();
        chg = (a < 2) ? (old_l ^ new_l) : 16'h0;
        @(negedge clk);
        bus_valid = 0; bus_write = 0;
        check({tag, " notify"}, 32'(lsn_notify), 32'(model_notify(chg)));
        check({tag, " change_mask"}, 32'(change_mask), 32'(chg));
        check({tag, " lines"}, 32'(pin_lines), 32'(new_l));
        @(negedge clk);
        check("R8 pulse ends", 32'(lsn_notify), 32'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check("R1 lines", 32'(pin_lines), 32'h0);
        check("R1 rvalid", 32'(bus_rvalid), 32'h0);
        check("R1 notify", 32'(lsn_notify), 32'h0);
        do_read(2'd0, 32'h0, "R1 cfg read");
        do_read(2'd1, 32'h0, "R1 levels read");

        // R5: drive register alone changes nothing while all pins are inputs
        do_write(2'd1, 32'h00FF, "R5 unchanged");
        // R2 R6 R7: even bits enable pins 0..7 -> 0x00FF, listeners 0 and 1
        do_write(2'd0, 32'h0000_5555, "R2 R6 R7 oe low byte");
        check("R7 expected pattern", 32'(model_notify(16'h00FF)), 32'h3);
        // R9 config readback
        do_read(2'd0, 32'h0000_5555, "R9 cfg readback");
        do_read(2'd1, 32'h0000_00FF, "R4 levels read");
        // R3: odd bits of pins 8..15 enable pull-ups; only listener 3 hit
        do_write(2'd0, 32'hAAAA_5555, "R3 pullups");
        // R3: peripheral overrides pull-ups on pins 8..11
        @(negedge clk);
        periph_dir = 16'h0F00; periph_data = 16'h0500;
        @(negedge clk);
        check("R3 periph drive", 32'(pin_lines), 32'hF5FF);
        check("R8 no notify on periph change", 32'(lsn_notify), 32'h0);
        // R6 R7: pins 0..3 drop, listener 0 only
        do_write(2'd1, 32'h00F0, "R6 low nibble");
        // R4: read returns resolved levels, not 0x00F0
        do_read(2'd1, 32'h0000_F5F0, "R4 resolved read");
        // R5 same value again
        do_write(2'd1, 32'h00F0, "R5 rewrite");
        // R10 unmapped
        do_write(2'd2, 32'hFFFF_FFFF, "R10 unmapped write");
        do_read(2'd3, 32'h0, "R10 unmapped read");
        do_read(2'd0, 32'hAAAA_5555, "R10 cfg kept");
        do_read(2'd1, 32'h0000_F5F0, "R10 drive kept");
        // R3 contention: cpu 0 vs periph 1 on pin 0
        @(negedge clk);
        periph_dir = 16'h0001; periph_data = 16'h0001;
        @(negedge clk);
        check("R3 wired-or", 32'(pin_lines), 32'hFFF1);
        // R6 R7: clear config, listeners 1 and 3
        do_write(2'd0, 32'h0, "R7 multi listener");
        // R8 back-to-back writes: capture per write
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_addr = 2'd1; bus_wdata = 32'h3;
        m_drv = 16'h3;
        @(negedge clk);
        check("R5 b2b first", 32'(lsn_notify), 32'h0);
        bus_addr = 2'd0; bus_wdata = 32'h5;
        m_cfg = 32'h5;
        @(negedge clk);
        bus_valid = 0; bus_write = 0;
        check("R6 b2b change", 32'(change_mask), 32'h0002);
        check("R7 b2b notify", 32'(lsn_notify), 32'h1);
        check("R3 b2b lines", 32'(pin_lines), 32'(model_lines()));
        @(negedge clk);
        check("R8 b2b end", 32'(lsn_notify), 32'h0);

        repeat (3) @(negedge clk);
        check("R9 queue drained", 32'(exp_q.size()), 32'h0);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule